// File: doc/BRIEF.md
# Vectored Masked Interrupt Controller

This block gathers eight event flags raised inside a dual-channel serial controller and turns them into one active-low interrupt request for a host processor. Software chooses which events may raise the request through a writable enable mask. A status register always shows the raw event levels, whatever the mask holds.

When the processor runs an interrupt-acknowledge cycle by pulling its acknowledge strobe low, the block responds only if an enabled event is pending. In that case it places a programmable 8-bit vector on the data bus and pulls the transfer-acknowledge line low. If nothing enabled is pending, it stays silent.

Five bits of a parallel output port can also serve as separate active-low interrupt lines, one per selected source. An auxiliary register switches each of these lines on individually. Address decoding and event generation sit outside the block and appear here as plain inputs.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, irq_n, dtack_n and every op_n bit are high, data_oe is low, the enable mask reads 0x00, the vector reads 0x0F and the auxiliary register reads 0x00.
- R2: irq_n is low in the cycle after ev_i has any bit set whose enable-mask bit is also set, and high otherwise.
- R3: A read of register select 0 (status) returns the current ev_i levels, including bits whose mask bit is clear.
- R4: Writes to select 1 (enable mask), select 2 (vector) and select 3 (auxiliary, bits 4:0) read back unchanged. A write to select 0 changes no register.
- R5: When iack_n is sampled low while irq_n is low, then from the next cycle dtack_n is low, data_oe is high and data_o holds the vector, for as long as iack_n stays low.
- R6: In the cycle after iack_n returns high, dtack_n is high and data_oe is low.
- R7: An acknowledge cycle with no enabled event pending gives no dtack_n and leaves data_oe low.
- R8: op_n[k] drives output-port bit 3+k. When auxiliary bit k is set, op_n[k] is low in the cycle after its source event is high, whatever the mask holds. The sources are: k0 from event 3, k1 from event 1, k2 from event 5, k3 from event 0 and k4 from event 4. When auxiliary bit k is clear, op_n[k] is high.
- R9: Read data appears on data_o with data_oe high in the cycle after cs and rd are sampled high. data_oe is low when no read or acknowledge is active.
- R10: When a read and a responding acknowledge occur together, the bus carries the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | 8 | Raw interrupt event levels |
| cs | input | 1 | Register access select |
| rd | input | 1 | Register read strobe |
| wr | input | 1 | Register write strobe |
| sel | input | 2 | Register select: 0 status, 1 mask, 2 vector, 3 auxiliary |
| wdata | input | 8 | Write data |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| data_o | output | 8 | Data bus output value |
| data_oe | output | 1 | Data bus drive enable; the bus is released when low |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| irq_n | output | 1 | Interrupt request, active low |
| op_n | output | 5 | Discrete interrupt lines for output-port bits 3 to 7, active low |

## Verification
The hardest case to reach from the ports is an acknowledge strobe that collides with a register read while an enabled event is pending, because both paths compete for the same bus. The stimulus first enables an event and raises it, then waits for irq_n to fall. It then lowers iack_n in the same cycle as a read strobe and checks that the vector wins. A second hard case is the silent acknowledge. The bench holds iack_n low over several cycles with events that are active but masked, and watches that dtack_n and data_oe never move.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_AUX  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int N_EV = 8,
  parameter int DW = 8,
  parameter int N_OP = 5,
  parameter logic [7:0] VEC_RST = 8'h0F
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_EV-1:0] ev_i,
  input  logic            wr_en,
  input  reg_sel_e        sel,
  input  logic [DW-1:0]   wdata,
  output logic [N_EV-1:0] ev_q,
  output logic [N_EV-1:0] mask_q,
  output logic [DW-1:0]   vec_q,
  output logic [N_OP-1:0] aux_q,
  output logic            irq_n,
  output logic [DW-1:0]   rd_mux
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q   <= '0;
      mask_q <= '0;
      vec_q  <= DW'(VEC_RST);
      aux_q  <= '0;
      irq_n  <= 1'b1;
    end else begin
      ev_q  <= ev_i;
      irq_n <= ~|(ev_i & mask_q);
      if (wr_en) begin
        case (sel)
          SEL_MASK: mask_q <= wdata[N_EV-1:0];
          SEL_VEC:  vec_q  <= wdata;
          SEL_AUX:  aux_q  <= wdata[N_OP-1:0];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_STAT: rd_mux[N_EV-1:0] = ev_q;
      SEL_MASK: rd_mux[N_EV-1:0] = mask_q;
      SEL_VEC:  rd_mux = vec_q;
      SEL_AUX:  rd_mux[N_OP-1:0] = aux_q;
      default:  rd_mux = '0;
    endcase
  end

  // R4: a write aimed at the status select leaves the writable registers alone
  p_status_ro_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_STAT) |=> ($stable(mask_q) && $stable(vec_q) && $stable(aux_q)));

  // R2: with the mask cleared for two cycles no request can be raised
  p_irq_masked_r2: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0 && $past(mask_q) == '0) |-> irq_n);
endmodule

// File: rtl/vic_ack.sv
module vic_ack #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iack_n,
  input  logic          pend,
  input  logic          rd_req,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] vec_q,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic          dtack_n
);
  logic ack_q;
  logic ack_nx;

  assign ack_nx = !iack_n && (ack_q || pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      dtack_n <= 1'b1;
      data_o  <= '0;
      data_oe <= 1'b0;
    end else begin
      ack_q   <= ack_nx;
      dtack_n <= !ack_nx;
      data_oe <= ack_nx || rd_req;
      if (ack_nx)      data_o <= vec_q;
      else if (rd_req) data_o <= rd_data;
    end
  end

  // R6: acknowledge only ever follows a low strobe in the previous cycle
  p_dtack_release_r6: assert property (@(posedge clk) disable iff (rst)
    $past(iack_n) |-> dtack_n);

  // R5: while acknowledging, the bus is driven
  p_dtack_drives_r5: assert property (@(posedge clk) disable iff (rst)
    !dtack_n |-> data_oe);

  // R7: acknowledge needs a pending event or an ongoing acknowledge
  p_no_silent_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && $past(dtack_n)) |-> $past(pend));
endmodule

// File: rtl/vic_discrete.sv
module vic_discrete #(
  parameter int N_EV = 8,
  parameter int N_OP = 5,
  parameter logic [N_OP*3-1:0] OP_SRC = {3'd4, 3'd0, 3'd5, 3'd1, 3'd3}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_EV-1:0] ev_i,
  input  logic [N_OP-1:0] aux_q,
  output logic [N_OP-1:0] op_n
);
  for (genvar k = 0; k < N_OP; k++) begin : g_line
    logic [2:0] src;
    assign src = OP_SRC[k*3 +: 3];
    always_ff @(posedge clk) begin
      if (rst) op_n[k] <= 1'b1;
      else     op_n[k] <= !(aux_q[k] && ev_i[src]);
    end
  end

  // R8: with every line disabled for two cycles all lines stay high
  p_lines_off_r8: assert property (@(posedge clk) disable iff (rst)
    (aux_q == '0 && $past(aux_q) == '0) |-> (&op_n));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int N_EV = 8,
  parameter int DW = 8,
  parameter int N_OP = 5,
  parameter logic [7:0] VEC_RST = 8'h0F
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_EV-1:0] ev_i,
  input  logic            cs,
  input  logic            rd,
  input  logic            wr,
  input  logic [1:0]      sel,
  input  logic [DW-1:0]   wdata,
  input  logic            iack_n,
  output logic [DW-1:0]   data_o,
  output logic            data_oe,
  output logic            dtack_n,
  output logic            irq_n,
  output logic [N_OP-1:0] op_n
);
  logic [N_EV-1:0] ev_q;
  logic [N_EV-1:0] mask_q;
  logic [DW-1:0]   vec_q;
  logic [N_OP-1:0] aux_q;
  logic [DW-1:0]   rd_mux;
  reg_sel_e        sel_e;

  assign sel_e = reg_sel_e'(sel);

  vic_regs #(.N_EV(N_EV), .DW(DW), .N_OP(N_OP), .VEC_RST(VEC_RST)) u_regs (
    .clk(clk), .rst(rst), .ev_i(ev_i), .wr_en(cs && wr), .sel(sel_e),
    .wdata(wdata), .ev_q(ev_q), .mask_q(mask_q), .vec_q(vec_q),
    .aux_q(aux_q), .irq_n(irq_n), .rd_mux(rd_mux)
  );

  vic_ack #(.DW(DW)) u_ack (
    .clk(clk), .rst(rst), .iack_n(iack_n), .pend(!irq_n),
    .rd_req(cs && rd), .rd_data(rd_mux), .vec_q(vec_q),
    .data_o(data_o), .data_oe(data_oe), .dtack_n(dtack_n)
  );

  vic_discrete #(.N_EV(N_EV), .N_OP(N_OP)) u_disc (
    .clk(clk), .rst(rst), .ev_i(ev_i), .aux_q(aux_q), .op_n(op_n)
  );

  // R5 and R10: during an acknowledge the bus carries the vector register
  p_ack_vector_r5: assert property (@(posedge clk) disable iff (rst)
    (!dtack_n && $past(!dtack_n)) |-> (data_o == vec_q));

  // R9: the bus is released when neither a read nor an acknowledge was seen
  p_bus_idle_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!(cs && rd)) && $past(iack_n)) |-> !data_oe);
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] ev_i;
  logic       cs, rd, wr;
  logic [1:0] sel;
  logic [7:0] wdata;
  logic       iack_n;
  logic [7:0] data_o;
  logic       data_oe, dtack_n, irq_n;
  logic [4:0] op_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vec_irq_ctrl dut (
    .clk(clk), .rst(rst), .ev_i(ev_i), .cs(cs), .rd(rd), .wr(wr),
    .sel(sel), .wdata(wdata), .iack_n(iack_n), .data_o(data_o),
    .data_oe(data_oe), .dtack_n(dtack_n), .irq_n(irq_n), .op_n(op_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; sel = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; sel = a;
    @(negedge clk);
    d = data_oe ? data_o : 8'hxx;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq_n", irq_n, 1);
    chk("R1 dtack_n", dtack_n, 1);
    chk("R1 data_oe", data_oe, 0);
    chk("R1 op_n", op_n, 5'h1F);
    rd_reg(2'd1, d); chk("R1 mask", d, 8'h00);
    rd_reg(2'd2, d); chk("R1 vector", d, 8'h0F);
    rd_reg(2'd3, d); chk("R1 aux", d, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] d;
    @(negedge clk); ev_i = 8'hA5;
    @(negedge clk); chk("R2 masked no irq", irq_n, 1);
    rd_reg(2'd0, d); chk("R3 raw status", d, 8'hA5);
    @(negedge clk); chk("R9 idle bus", data_oe, 0);
    ev_i = 8'h00;
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr_reg(2'd2, 8'h42);
    wr_reg(2'd1, 8'h04);
    wr_reg(2'd3, 8'h15);
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd1, d); chk("R4 mask", d, 8'h04);
    rd_reg(2'd2, d); chk("R4 vector", d, 8'h42);
    rd_reg(2'd3, d); chk("R4 aux", d, 8'h15);
    wr_reg(2'd3, 8'h00);
  endtask

  task automatic t_irq();
    @(negedge clk); ev_i = 8'h04;
    @(negedge clk); chk("R2 irq low", irq_n, 0);
    ev_i = 8'h01;
    @(negedge clk); chk("R2 irq high on masked", irq_n, 1);
    ev_i = 8'h00;
  endtask

  task automatic t_iack();
    @(negedge clk); ev_i = 8'h04;
    @(negedge clk); chk("R2 pending", irq_n, 0);
    iack_n = 1'b0;
    @(negedge clk);
    chk("R5 dtack", dtack_n, 0);
    chk("R5 oe", data_oe, 1);
    chk("R5 vector", data_o, 8'h42);
    @(negedge clk);
    chk("R5 held", dtack_n, 0);
    iack_n = 1'b1;
    @(negedge clk);
    chk("R6 dtack released", dtack_n, 1);
    chk("R6 bus released", data_oe, 0);
  endtask

  task automatic t_iack_none();
    @(negedge clk); ev_i = 8'hFB;
    @(negedge clk); iack_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 no dtack", dtack_n, 1);
      chk("R7 no drive", data_oe, 0);
    end
    iack_n = 1'b1; ev_i = 8'h00;
  endtask

  task automatic t_priority();
    @(negedge clk); ev_i = 8'h04;
    @(negedge clk);
    iack_n = 1'b0; cs = 1'b1; rd = 1'b1; sel = 2'd1;
    @(negedge clk);
    chk("R10 vector wins", data_o, 8'h42);
    chk("R10 dtack", dtack_n, 0);
    cs = 1'b0; rd = 1'b0; iack_n = 1'b1; ev_i = 8'h00;
    @(negedge clk);
  endtask

  task automatic t_discrete();
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd3, 8'h1F);
    ev_i = 8'h08;
    @(negedge clk); chk("R8 event3 line0", op_n, 5'h1E);
    ev_i = 8'h31;
    @(negedge clk); chk("R8 events 0,4,5", op_n, 5'h03);
    ev_i = 8'h02;
    @(negedge clk); chk("R8 event1 line1", op_n, 5'h1D);
    chk("R8 mask ignored irq", irq_n, 1);
    wr_reg(2'd3, 8'h01);
    ev_i = 8'hFF;
    @(negedge clk); chk("R8 only enabled line", op_n, 5'h1E);
    wr_reg(2'd3, 8'h00);
    @(negedge clk); chk("R8 disabled", op_n, 5'h1F);
    ev_i = 8'h00;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ev_i = '0; cs = 0; rd = 0; wr = 0; sel = '0;
    wdata = '0; iack_n = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_status();
    t_regs();
    t_irq();
    t_iack();
    t_iack_none();
    t_priority();
    t_discrete();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule